// File: doc/BRIEF.md
# Effective Address Generator for 32-bit Register/Memory Operands

This block takes the operand-addressing bytes of a 32-bit instruction: the mode/register/operand byte, the optional scaled-index byte and the displacement field. It decides whether the operand is a general register or a memory location. For a memory operand it computes the linear address from a base register, a scaled index register, a displacement, and a default segment value shifted left by 16 bits.

The block reads two general registers through read ports that it drives. It reads the current DS and SS values directly. Results are registered: one cycle after the `valid_i` strobe, `valid_o` rises and the outputs carry the decoded operand. The outputs hold their values until the next strobe.

Only 32-bit address size is handled. Prefixes, segment overrides and the memory access itself belong to other blocks.

Top module: `ea_gen`

## Requirements
- R1: When mod (`modrm_i[7:6]`) is 11, the result is register-direct: `is_mem_o`=0, `reg_idx_o` = r/m (`modrm_i[2:0]`), `lin_addr_o`=0, `seg_ss_o`=0.
- R2: When mod is 01, `disp_i[7:0]` is sign-extended to 32 bits and added to the base; `disp_i[31:8]` has no effect.
- R3: When mod is 10, the full 32-bit `disp_i` is added to the base.
- R4: When mod is 00 and r/m is neither 100 nor 101, the address is the base register alone, and `disp_i` has no effect.
- R5: When mod is 00 and r/m is 101, no base register is used, the address is `disp_i` plus the segment term, and DS is chosen.
- R6: When r/m is 100 and mod is not 11, the scaled-index byte is used: `sib_i[7:6]` scales the index by 1, 2, 4 or 8; `sib_i[5:3]` selects the index register; and `sib_i[2:0]` selects the base register.
- R7: A scaled-index index field of 100 means that no index is added.
- R8: A scaled-index base field of 101 with mod 00 means that no base is used and the 32-bit `disp_i` is added (the index still applies), with DS chosen.
- R9: `seg_ss_o`=1 (SS) exactly when a base register is used and its number is 100 or 101. Otherwise `seg_ss_o`=0 (DS).
- R10: `lin_addr_o` = base + (index << scale) + displacement + (chosen segment << 16), modulo 2^32.
- R11: `valid_o` is high in exactly the cycle after each cycle with `valid_i` high. After reset, all outputs are 0.
- R12: For a memory operand, `reg_idx_o` carries the reg field (`modrm_i[5:3]`). While `valid_i` is low, every data output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand bytes are present this cycle |
| modrm_i | input | 8 | Mode/reg/rm byte |
| sib_i | input | 8 | Scale/index/base byte |
| disp_i | input | 32 | Displacement field (low byte used for mod 01) |
| ds_i | input | 16 | DS segment value |
| ss_i | input | 16 | SS segment value |
| base_idx_o | output | 3 | Register-file read address for the base |
| base_data_i | input | 32 | Base register value |
| index_idx_o | output | 3 | Register-file read address for the index |
| index_data_i | input | 32 | Index register value |
| valid_o | output | 1 | Result valid |
| is_mem_o | output | 1 | 1 = memory operand, 0 = register-direct |
| reg_idx_o | output | 3 | r/m register (direct) or reg field (memory) |
| seg_ss_o | output | 1 | Default segment: 1 = SS, 0 = DS |
| lin_addr_o | output | 32 | Linear address |

## Verification
The hardest cases to reach are the mod-00 encodings that remove the base register. In these cases the number 101 stops naming EBP: the stack segment must not be picked, and a displacement that is otherwise ignored must be added. A similar case arises inside the scaled-index byte, where an index field of 100 must suppress an ESP index. Random bytes hit these encodings only one time in many. The stimulus therefore runs directed vectors for each of them with distinct register, segment and displacement values, so that any wrong choice of term changes the sum. A long random run then covers scale values, sign-extension and wrap-around.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic {SEG_DS = 1'b0, SEG_SS = 1'b1} seg_sel_e;

  typedef enum logic [1:0] {DISP_NONE = 2'd0, DISP_8 = 2'd1, DISP_32 = 2'd2} disp_kind_e;

  typedef struct packed {
    logic       is_mem;
    logic       base_en;
    logic [2:0] base_idx;
    logic       index_en;
    logic [2:0] index_idx;
    logic [1:0] scale;
    disp_kind_e disp_kind;
  } ea_ctl_t;

  localparam logic [1:0] MOD_REG    = 2'b11;
  localparam logic [1:0] MOD_NODISP = 2'b00;
  localparam logic [1:0] MOD_D8     = 2'b01;
  localparam logic [2:0] RM_SIB     = 3'b100;
  localparam logic [2:0] RM_D32     = 3'b101;
  localparam logic [2:0] IDX_NONE   = 3'b100;
  localparam logic [2:0] GPR_ESP    = 3'b100;
  localparam logic [2:0] GPR_EBP    = 3'b101;
endpackage

// File: rtl/ea_field_decode.sv
module ea_field_decode
  import ea_pkg::*;
(
  input  logic [7:0] modrm_i,
  input  logic [7:0] sib_i,
  output ea_ctl_t    ctl_o,
  output seg_sel_e   seg_o,
  output logic [2:0] reg_idx_o
);
  logic [1:0] mode;
  logic [2:0] rm;
  ea_ctl_t    ctl;

  assign mode = modrm_i[7:6];
  assign rm   = modrm_i[2:0];

  always_comb begin
    ctl = '0;
    ctl.disp_kind = DISP_NONE;
    if (mode != MOD_REG) begin
      ctl.is_mem = 1'b1;
      unique case (mode)
        MOD_D8:  ctl.disp_kind = DISP_8;
        2'b10:   ctl.disp_kind = DISP_32;
        default: ctl.disp_kind = DISP_NONE;
      endcase
      if (rm == RM_SIB) begin
        ctl.scale     = sib_i[7:6];
        ctl.index_idx = sib_i[5:3];
        ctl.index_en  = (sib_i[5:3] != IDX_NONE);
        ctl.base_idx  = sib_i[2:0];
        ctl.base_en   = !(mode == MOD_NODISP && sib_i[2:0] == RM_D32);
      end else begin
        ctl.base_idx  = rm;
        ctl.base_en   = !(mode == MOD_NODISP && rm == RM_D32);
      end
      // absent base in mode 00 is replaced by a full displacement
      if (!ctl.base_en) ctl.disp_kind = DISP_32;
    end
  end

  assign ctl_o     = ctl;
  assign seg_o     = (ctl.base_en && (ctl.base_idx == GPR_ESP || ctl.base_idx == GPR_EBP))
                     ? SEG_SS : SEG_DS;
  assign reg_idx_o = ctl.is_mem ? modrm_i[5:3] : rm;
endmodule

// File: rtl/ea_sum.sv
module ea_sum
  import ea_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned SEG_SHIFT = 16
) (
  input  ea_ctl_t           ctl_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic [SEG_W-1:0]  seg_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned D8_W = 8;

  logic [ADDR_W-1:0] base_term, index_term, disp_term, seg_term;

  assign base_term  = ctl_i.base_en ? base_i : '0;
  assign index_term = ctl_i.index_en ? (index_i << ctl_i.scale) : '0;

  always_comb begin
    unique case (ctl_i.disp_kind)
      DISP_8:  disp_term = {{(ADDR_W-D8_W){disp_i[D8_W-1]}}, disp_i[D8_W-1:0]};
      DISP_32: disp_term = disp_i;
      default: disp_term = '0;
    endcase
  end

  generate
    if (SEG_SHIFT + SEG_W <= ADDR_W) begin : g_seg_fit
      assign seg_term = ADDR_W'(seg_i) << SEG_SHIFT;
    end else begin : g_seg_trunc
      logic [SEG_W+SEG_SHIFT-1:0] seg_wide;
      assign seg_wide = {seg_i, {SEG_SHIFT{1'b0}}};
      assign seg_term = seg_wide[ADDR_W-1:0];
    end
  endgenerate

  assign addr_o = ctl_i.is_mem ? (base_term + index_term + disp_term + seg_term) : '0;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned SEG_SHIFT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        modrm_i,
  input  logic [7:0]        sib_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic [SEG_W-1:0]  ds_i,
  input  logic [SEG_W-1:0]  ss_i,
  output logic [2:0]        base_idx_o,
  input  logic [ADDR_W-1:0] base_data_i,
  output logic [2:0]        index_idx_o,
  input  logic [ADDR_W-1:0] index_data_i,
  output logic              valid_o,
  output logic              is_mem_o,
  output logic [2:0]        reg_idx_o,
  output logic              seg_ss_o,
  output logic [ADDR_W-1:0] lin_addr_o
);
  ea_ctl_t           ctl;
  seg_sel_e          seg_sel;
  logic [2:0]        reg_idx_d;
  logic [SEG_W-1:0]  seg_val;
  logic [ADDR_W-1:0] addr_d;

  ea_field_decode u_dec (
    .modrm_i   (modrm_i),
    .sib_i     (sib_i),
    .ctl_o     (ctl),
    .seg_o     (seg_sel),
    .reg_idx_o (reg_idx_d)
  );

  assign base_idx_o  = ctl.base_idx;
  assign index_idx_o = ctl.index_idx;
  assign seg_val     = (seg_sel == SEG_SS) ? ss_i : ds_i;

  ea_sum #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT)) u_sum (
    .ctl_i   (ctl),
    .base_i  (base_data_i),
    .index_i (index_data_i),
    .disp_i  (disp_i),
    .seg_i   (seg_val),
    .addr_o  (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      is_mem_o   <= 1'b0;
      reg_idx_o  <= '0;
      seg_ss_o   <= 1'b0;
      lin_addr_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        is_mem_o   <= ctl.is_mem;
        reg_idx_o  <= reg_idx_d;
        seg_ss_o   <= (seg_sel == SEG_SS);
        lin_addr_o <= addr_d;
      end
    end
  end

  p_valid_follow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid_o missing after strobe");
  p_valid_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("valid_o without strobe");
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(lin_addr_o) && $stable(is_mem_o) && $stable(seg_ss_o)))
    else $error("outputs moved while idle");
  p_reg_direct_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && modrm_i[7:6] == MOD_REG) |=> (!is_mem_o && lin_addr_o == '0 && !seg_ss_o))
    else $error("register-direct produced an address");
  p_d32_ds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && modrm_i[7:6] == MOD_NODISP && modrm_i[2:0] == RM_D32) |=> !seg_ss_o)
    else $error("disp32-only form chose SS");
  p_sib_nobase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && modrm_i[7:6] == MOD_NODISP && modrm_i[2:0] == RM_SIB && sib_i[2:0] == RM_D32)
    |=> (is_mem_o && !seg_ss_o)) else $error("scaled no-base form chose SS");
endmodule

// File: tb/ea_gen_test.sv
module ea_gen_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  modrm = '0, sib = '0;
  logic [31:0] disp = '0;
  logic [15:0] ds = '0, ss = '0;
  logic [2:0]  base_idx, index_idx;
  logic [31:0] base_data, index_data;
  logic        valid_o, is_mem;
  logic [2:0]  reg_idx;
  logic        seg_ss;
  logic [31:0] lin_addr;
  logic [31:0] gpr [8];

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign base_data  = gpr[base_idx];
  assign index_data = gpr[index_idx];

  ea_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .modrm_i(modrm), .sib_i(sib),
    .disp_i(disp), .ds_i(ds), .ss_i(ss), .base_idx_o(base_idx), .base_data_i(base_data),
    .index_idx_o(index_idx), .index_data_i(index_data), .valid_o(valid_o),
    .is_mem_o(is_mem), .reg_idx_o(reg_idx), .seg_ss_o(seg_ss), .lin_addr_o(lin_addr)
  );

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (modrm=%h sib=%h)", req, act, exp, modrm, sib);
    end
  endtask

  // expected result model built from the requirements
  function automatic void model(input logic [7:0] m, input logic [7:0] s, input logic [31:0] d,
                                output logic e_mem, output logic [2:0] e_reg,
                                output logic e_ss, output logic [31:0] e_addr);
    logic [1:0] md = m[7:6];
    logic [2:0] rm = m[2:0];
    logic has_base = 1'b1;
    logic [2:0] b = rm;
    logic [31:0] sum = 0;
    logic [31:0] dv;
    e_mem = (md != 2'b11);
    e_reg = e_mem ? m[5:3] : rm;
    e_ss = 1'b0;
    e_addr = 0;
    if (!e_mem) return;
    dv = (md == 2'b01) ? {{24{d[7]}}, d[7:0]} : (md == 2'b10) ? d : 32'h0;
    if (rm == 3'b100) begin
      b = s[2:0];
      if (s[5:3] != 3'b100) sum = gpr[s[5:3]] << s[7:6];
      if (md == 2'b00 && s[2:0] == 3'b101) begin has_base = 0; dv = d; end
    end else if (md == 2'b00 && rm == 3'b101) begin
      has_base = 0; dv = d;
    end
    if (has_base) sum += gpr[b];
    e_ss = has_base && (b == 3'b100 || b == 3'b101);
    e_addr = sum + dv + {(e_ss ? ss : ds), 16'h0};
  endfunction

  task automatic run(input string req, input logic [7:0] m, input logic [7:0] s, input logic [31:0] d);
    logic em, es; logic [2:0] er; logic [31:0] ea;
    @(negedge clk);
    modrm = m; sib = s; disp = d; valid_i = 1'b1;
    model(m, s, d, em, er, es, ea);
    @(negedge clk);
    valid_i = 1'b0;
    check({req, " valid"}, 32'(valid_o), 32'd1);
    check({req, " is_mem"}, 32'(is_mem), 32'(em));
    check({req, " reg_idx"}, 32'(reg_idx), 32'(er));
    check({req, " seg_ss"}, 32'(seg_ss), 32'(es));
    check({req, " addr"}, lin_addr, ea);
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) gpr[i] = 32'h1000_0000 * (i + 1) + 32'h11 * i;
    ds = 16'h00D5; ss = 16'h0055;
    #(CLK_PERIOD * 2 + 1ns);
    check("R11 reset valid", 32'(valid_o), 0);
    check("R11 reset addr", lin_addr, 0);
    check("R11 reset is_mem", 32'(is_mem), 0);
    rst_n = 1'b1;

    run("R1 reg direct", 8'hC3, 8'h00, 32'hFFFF_FFFF);
    run("R1 reg direct esp", 8'hFC, 8'hFF, 32'h1234_5678);
    run("R2 disp8 neg", 8'h41, 8'h00, 32'hABCD_EF80);
    run("R2 disp8 pos", 8'h7E, 8'h00, 32'hFFFF_FF7F);
    run("R3 disp32", 8'h82, 8'h00, 32'h8765_4321);
    run("R4 base only", 8'h07, 8'h00, 32'hDEAD_BEEF);
    run("R5 disp32 only", 8'h05, 8'h00, 32'h0001_2345);
    run("R6 sib scale8", 8'h84, 8'hCA, 32'h0000_0010);
    run("R6 sib scale2", 8'h44, 8'h5B, 32'h0000_00F0);
    run("R7 sib no index", 8'h04, 8'hE1, 32'h5555_5555);
    run("R8 sib no base", 8'h04, 8'h8D, 32'h0000_4000);
    run("R8 sib no base no idx", 8'h04, 8'h25, 32'h0BAD_0000);
    run("R9 esp base ss", 8'h04, 8'h24, 32'h0);
    run("R9 ebp base ss", 8'h45, 8'h00, 32'h0000_0008);
    run("R9 sib ebp base mod01", 8'h44, 8'h05, 32'h0000_0001);
    run("R9 ebp index ds", 8'h04, 8'h28, 32'h0);
    gpr[3] = 32'hFFFF_FFF0;
    run("R10 wrap", 8'h83, 8'h00, 32'h0000_0020);

    // R12 idle hold: inputs change with no strobe
    held = lin_addr;
    @(negedge clk);
    modrm = 8'hC0; sib = 8'h00; disp = 32'h1;
    @(negedge clk);
    check("R12 hold addr", lin_addr, held);
    check("R11 idle valid", 32'(valid_o), 0);

    for (int n = 0; n < 400; n++) begin
      for (int r = 0; r < 8; r++) gpr[r] = $urandom;
      ds = 16'($urandom); ss = 16'($urandom);
      run("R10 random", 8'($urandom), 8'($urandom), $urandom);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule